// File: doc/BRIEF.md
# Edge-to-Edge Interval Measurement Counter

The block times the gap between two successive qualifying edges on an external interrupt line that has already been noise filtered. A free-running prescaler turns the system clock into a slow sampling tick, and an up counter advances once per tick. Each qualifying edge after the first copies the running count into a result register, raises a one-cycle interval interrupt and restarts the count at zero. Measurement therefore runs back to back with no dead time.

If no edge arrives before the counter reaches its maximum value, the counter holds at that value. On the next sampling tick it writes the maximum into the result register and raises a one-cycle overflow interrupt. After that it waits, and the next qualifying edge starts a new measurement from zero without producing a capture. The edge polarity and the tick rate are set by plain control inputs. Clearing the enable input stops all activity and restarts the prescaler.

Top module: `edge_interval_meter`

## Requirements
- R1: After reset the result output is 0 and both interrupt outputs are low.
- R2: While `enable` is 0, edges on `sig_in` raise no interrupt, and the prescaler and counter are held at zero.
- R3: The first qualifying edge after `enable` rises starts timing from zero and raises no interrupt. The result is left unchanged.
- R4: On each later qualifying edge, in the cycle after the edge is sampled, `interval` equals the number of sampling ticks that occurred strictly between the two edges and `irq_interval` is high for exactly one cycle.
- R5: With `slow_sel` = 0 the sampling tick period is 2^(PRE_W-1) clocks; with `slow_sel` = 1 it is 2^PRE_W clocks. The prescaler restarts on enable, so the first tick falls on the period-th clock edge at which `enable` is sampled high.
- R6: With `fall_sel` = 0 only low-to-high transitions of `sig_in` qualify; with `fall_sel` = 1 only high-to-low transitions qualify. The opposite transition has no effect.
- R7: The count stops at its all-ones maximum. On the first tick after the maximum is reached, `interval` becomes all ones and `irq_overflow` pulses for one cycle.
- R8: Each stall gives exactly one overflow pulse. The qualifying edge that ends a stall raises no interval interrupt, keeps the result, and restarts timing from zero.
- R9: When a qualifying edge and a sampling tick fall in the same cycle, the edge wins: the count is captured and cleared, and is not incremented.
- R10: `irq_interval` and `irq_overflow` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Measurement enable; low holds the block idle |
| fall_sel | input | 1 | Qualifying edge: 0 rising, 1 falling |
| slow_sel | input | 1 | Tick period: 0 gives 2^(PRE_W-1) clocks, 1 gives 2^PRE_W clocks |
| sig_in | input | 1 | Filtered interrupt line |
| interval | output | CNT_W | Last captured interval, or all ones after an overflow |
| irq_interval | output | 1 | One-cycle pulse on each capture |
| irq_overflow | output | 1 | One-cycle pulse when the count overflows |

## Verification
On every cycle the assertions check that the two interrupts never coincide and that an overflow pulse always comes with an all-ones result. They also check that a disabled block stays silent, that an edge always leaves the counter at zero, that a stall yields no second overflow pulse, and that ticks are never adjacent. The exact captured values, the tick phase after enable, the precise overflow cycle, and the missing capture on the edge that ends a stall depend on the whole history of the input. Only the bench's sweeps over edge gaps can show these, for each polarity and each tick rate, with the expected values worked out from cycle numbers.

// File: rtl/ivm_pkg.sv
package ivm_pkg;
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;
endpackage

// File: rtl/ivm_prescaler.sv
module ivm_prescaler #(
    parameter int PRE_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic slow_i,
    output logic tick_o
);
    logic [PRE_W-1:0] div_d, div_q;

    always_comb begin
        div_d = en_i ? div_q + 1'b1 : '0;
        if (slow_i) tick_o = en_i && (&div_q);
        else        tick_o = en_i && (&div_q[PRE_W-2:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/ivm_edge_detect.sv
module ivm_edge_detect
    import ivm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    input  logic pol_i,
    output logic edge_o
);
    logic      prev_d, prev_q;
    edge_pol_e pol;

    always_comb begin
        pol    = edge_pol_e'(pol_i);
        prev_d = sig_i;
        if (pol == EDGE_FALL) edge_o = prev_q && !sig_i;
        else                  edge_o = !prev_q && sig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/ivm_core.sv
module ivm_core #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             edge_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] result_o,
    output logic             ivl_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] res;
        logic             ivl;
        logic             ovf;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ivl = 1'b0;
        st_d.ovf = 1'b0;
        if (!en_i) begin
            st_d.run  = 1'b0;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (edge_i) begin
            if (st_q.run && !st_q.done) begin
                st_d.res = st_q.cnt;
                st_d.ivl = 1'b1;
            end
            st_d.run  = 1'b1;
            st_d.done = 1'b0;
            st_d.cnt  = '0;
        end else if (tick_i && st_q.run && !st_q.done) begin
            if (st_q.cnt == CNT_MAX) begin
                st_d.res  = CNT_MAX;
                st_d.ovf  = 1'b1;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;
    assign ivl_o    = st_q.ivl;
    assign ovf_o    = st_q.ovf;

    // R10
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ivl && st_q.ovf));
    // R7
    ovf_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ovf |-> st_q.res == CNT_MAX);
    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !st_q.ivl && !st_q.ovf && st_q.cnt == '0);
    // R9
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && edge_i |=> st_q.cnt == '0 && st_q.run);
    // R8
    ovf_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done && !edge_i |=> !st_q.ovf);
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i && !edge_i && st_q.cnt == CNT_MAX |=> st_q.cnt == CNT_MAX);
endmodule

// File: rtl/edge_interval_meter.sv
module edge_interval_meter #(
    parameter int CNT_W = 8,
    parameter int PRE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fall_sel,
    input  logic             slow_sel,
    input  logic             sig_in,
    output logic [CNT_W-1:0] interval,
    output logic             irq_interval,
    output logic             irq_overflow
);
    logic tick, qual_edge;

    ivm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (enable),
        .slow_i(slow_sel),
        .tick_o(tick)
    );

    ivm_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_i (sig_in),
        .pol_i (fall_sel),
        .edge_o(qual_edge)
    );

    ivm_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable),
        .edge_i  (qual_edge),
        .tick_i  (tick),
        .result_o(interval),
        .ivl_o   (irq_interval),
        .ovf_o   (irq_overflow)
    );
endmodule

// File: tb/sim_edge_interval_meter.sv
module sim_edge_interval_meter;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 4;
    localparam int PRE_W = 3;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, fall_sel = 1'b0, slow_sel = 1'b0, sig = 1'b0;
    logic [CNT_W-1:0] interval;
    logic irq_ivl, irq_ovf;

    int n_chk = 0, n_fail = 0;
    int ncyc = 0;
    int ivl_seen = 0, ovf_seen = 0, ovf_at = 0, both_seen = 0;

    edge_interval_meter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(en), .fall_sel(fall_sel),
        .slow_sel(slow_sel), .sig_in(sig), .interval(interval),
        .irq_interval(irq_ivl), .irq_overflow(irq_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) ncyc <= en ? ncyc + 1 : 0;

    always @(negedge clk) begin
        if (irq_ivl) ivl_seen++;
        if (irq_ovf) begin ovf_seen++; ovf_at = ncyc; end
        if (irq_ivl && irq_ovf) both_seen++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic run_combo(input bit pol, input bit div);
        int p, a, b, expv, t, ovf_base, ivl_base;
        p = div ? (1 << PRE_W) : (1 << (PRE_W - 1));
        en = 1'b0; fall_sel = pol; slow_sel = div; sig = pol;
        step(3);
        en = 1'b1;
        step(3);
        // R3: first edge starts timing without an interrupt
        ivl_base = ivl_seen;
        a = ncyc + 1; sig = !pol;
        step(1);
        check(irq_ivl == 1'b0 && ivl_seen == ivl_base, "R3", irq_ivl, 0);
        sig = pol;
        ovf_base = ovf_seen;
        for (int g = 2; g <= (MAXV + 2) * p; g++) begin
            step(1);
            // R6: opposite transition ignored
            check(irq_ivl == 1'b0, "R6", irq_ivl, 0);
            if (g > 2) step(g - 2);
            b = ncyc + 1; sig = !pol;
            step(1);
            expv = (b - 1) / p - a / p;
            if (expv <= MAXV) begin
                // R4, R5 (tick spacing), R9 when an edge coincides with a tick
                check(irq_ivl == 1'b1, (b % p == 0 || a % p == 0) ? "R9" : "R4", irq_ivl, 1);
                check(int'(interval) == expv, (b % p == 0 || a % p == 0) ? "R9" : "R5", interval, expv);
                check(ovf_seen == ovf_base, "R7", ovf_seen - ovf_base, 0);
            end else begin
                t = (a / p + MAXV + 1) * p;
                check(irq_ivl == 1'b0, "R8", irq_ivl, 0);
                check(ovf_seen - ovf_base == 1, "R8", ovf_seen - ovf_base, 1);
                check(ovf_at == t, "R7", ovf_at, t);
                check(int'(interval) == MAXV, "R7", interval, MAXV);
            end
            sig = pol;
            a = b;
            ovf_base = ovf_seen;
        end
        check(both_seen == 0, "R10", both_seen, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int i0, o0;
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1
        check(interval == '0, "R1", interval, 0);
        check(irq_ivl == 1'b0, "R1", irq_ivl, 0);
        check(irq_ovf == 1'b0, "R1", irq_ovf, 0);
        // R2: toggling while disabled
        i0 = ivl_seen; o0 = ovf_seen;
        for (int k = 0; k < 40; k++) begin
            sig = ~sig;
            step(3);
        end
        sig = 1'b0;
        step(200);
        check(ivl_seen == i0, "R2", ivl_seen - i0, 0);
        check(ovf_seen == o0, "R2", ovf_seen - o0, 0);
        check(interval == '0, "R2", interval, 0);
        for (int pl = 0; pl < 2; pl++)
            for (int dv = 0; dv < 2; dv++)
                run_combo(pl[0], dv[0]);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule